// File: doc/BRIEF.md
# Load/Store Address Dependency Matrix

This block keeps the memory-ordering hazards among a fixed set of N load/store units. It holds an N-by-N bit matrix: bit (i,j) set means unit i must wait for unit j. When a unit is issued, its row is loaded with every unit that was already outstanding before that cycle. The bit clears when the older unit retires, or when both units have generated addresses whose low-order bits differ, because two such accesses cannot touch the same location.

Every unordered pair of units has its own inequality comparator. The pairs form a triangle of N*(N-1)/2 comparators, and each comparator result releases both mirror cells of the matrix. Any number of units may present addresses in the same cycle. Each new address is compared with every stored address and with every other new address at once, so there is no arbitration and no stall. A per-unit proceed flag is high while that unit's row is empty. The raw matrix is also an output, for debug.

Top module: `lsu_order_matrix`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every matrix bit is 0 and every proceed flag is 1.
- R2: When `issue_vld[i]` is high and unit i is not retiring, row i becomes, at the next edge, exactly the set of other units that were outstanding before that cycle. Units issued in the same cycle are not included. No other event sets a matrix bit.
- R3: The diagonal bit (i,i) is always 0. Issuing unit i also clears column i.
- R4: When units i and j both have known addresses and the low `CW` address bits differ, bits (i,j) and (j,i) are both 0 after the next edge.
- R5: When the low `CW` bits are equal, a set bit is kept, even if the upper address bits differ.
- R6: Several units may assert `agen_vld` in one cycle. Every pair among them is compared in that same cycle, and no request is delayed.
- R7: An address accepted earlier stays stored until the unit retires or is reissued, and it is compared against each newly arriving address.
- R8: `retire_vld[k]` clears row k and column k, the outstanding state of unit k and its stored address at the next edge. Retire takes priority over issue in the same cycle.
- R9: An address presented by a unit in the same cycle as that unit's issue or retire is ignored.
- R10: `proceed[i]` is high exactly when row i is all zero, with no added cycle. The matrix bit layout is bit index i*N+j = unit i waits for unit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | N | Per-unit issue pulse |
| agen_vld | input | N | Per-unit address-generated strobe |
| agen_addr | input | N*AW | Unit i address in bits [i*AW +: AW] |
| retire_vld | input | N | Per-unit retire pulse |
| proceed | output | N | Unit i has no pending dependency |
| dep_matrix | output | N*N | Bit i*N+j: unit i waits on unit j |

## Verification
A wrong cell or a wrong comparator result shows on `dep_matrix` one edge after the event that should have changed it. It also shows on `proceed` in the same cycle, because that flag is pure logic over the registered row. A lost stored address stays hidden until a later arrival should release a pair against it. The bench therefore leaves idle cycles after issues, and then sends an arrival that must interact with a stored value. It compares the full matrix after every edge.

// File: rtl/lsom_pkg.sv
package lsom_pkg;

    localparam int unsigned LSOM_UNITS  = 4;
    localparam int unsigned LSOM_ADDR_W = 32;
    localparam int unsigned LSOM_CMP_W  = 12;

    // Control of one unit as seen by a matrix cell
    typedef struct packed {
        logic issue;
        logic retire;
    } slot_ctl_t;

    typedef enum logic [1:0] {
        CELL_HOLD  = 2'd0,
        CELL_LOAD  = 2'd1,
        CELL_CLEAR = 2'd2
    } cell_op_e;

    // Number of unordered unit pairs
    function automatic int unsigned pair_count(input int unsigned n);
        return (n * (n - 1)) / 2;
    endfunction

    // Packed position of pair (lo,hi), lo < hi, in the upper triangle
    function automatic int unsigned tri_index(input int unsigned n,
                                              input int unsigned lo,
                                              input int unsigned hi);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

    // Cell action: retire of either side beats issue, issue beats release
    function automatic cell_op_e cell_action(input slot_ctl_t row_c,
                                             input slot_ctl_t col_c,
                                             input logic differ);
        if (row_c.retire || col_c.retire) return CELL_CLEAR;
        if (row_c.issue)                  return CELL_LOAD;
        if (col_c.issue)                  return CELL_CLEAR;
        if (differ)                       return CELL_CLEAR;
        return CELL_HOLD;
    endfunction

endpackage

// File: rtl/lsom_unit_slot.sv
module lsom_unit_slot #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic          retire,
    input  logic          agen_vld,
    input  logic [CW-1:0] agen_low,
    output logic          outstanding,
    output logic          known_eff,
    output logic [CW-1:0] addr_eff
);
    logic          out_q;
    logic          known_q;
    logic [CW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= 1'b0;
            known_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (retire)     out_q <= 1'b0;
            else if (issue) out_q <= 1'b1;

            if (retire || issue) begin
                known_q <= 1'b0;
            end else if (agen_vld) begin
                known_q <= 1'b1;
                addr_q  <= agen_low;
            end
        end
    end

    // A fresh address takes part in comparisons in its arrival cycle
    assign outstanding = out_q;
    assign known_eff   = (known_q | agen_vld) & ~issue & ~retire;
    assign addr_eff    = agen_vld ? agen_low : addr_q;

endmodule

// File: rtl/lsom_pair_cmp.sv
module lsom_pair_cmp #(
    parameter int unsigned CW = 12
) (
    input  logic          known_a,
    input  logic          known_b,
    input  logic [CW-1:0] addr_a,
    input  logic [CW-1:0] addr_b,
    output logic          differ
);
    // Equal low bits may alias: keep the dependency
    assign differ = known_a & known_b & (addr_a != addr_b);
endmodule

// File: rtl/lsom_dep_cell.sv
module lsom_dep_cell
    import lsom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_ctl_t row_ctl,
    input  slot_ctl_t col_ctl,
    input  logic      col_outstanding,
    input  logic      differ,
    output logic      dep
);
    cell_op_e op;
    logic     dep_q;

    always_comb op = cell_action(row_ctl, col_ctl, differ);

    always_ff @(posedge clk) begin
        if (rst) begin
            dep_q <= 1'b0;
        end else begin
            unique case (op)
                CELL_LOAD:  dep_q <= col_outstanding;
                CELL_CLEAR: dep_q <= 1'b0;
                default:    dep_q <= dep_q;
            endcase
        end
    end

    assign dep = dep_q;
endmodule

// File: rtl/lsu_order_matrix.sv
module lsu_order_matrix
    import lsom_pkg::*;
#(
    parameter int unsigned N  = LSOM_UNITS,
    parameter int unsigned AW = LSOM_ADDR_W,
    parameter int unsigned CW = LSOM_CMP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    issue_vld,
    input  logic [N-1:0]    agen_vld,
    input  logic [N*AW-1:0] agen_addr,
    input  logic [N-1:0]    retire_vld,
    output logic [N-1:0]    proceed,
    output logic [N*N-1:0]  dep_matrix
);
    localparam int unsigned NPAIR = pair_count(N);

    slot_ctl_t        ctl [N];
    logic [N-1:0]     outstanding;
    logic [N-1:0]     known_eff;
    logic [CW-1:0]    addr_eff [N];
    logic [NPAIR-1:0] pair_differ;
    logic             addr_hi_unused;

    // Only the low CW bits take part in the comparison
    assign addr_hi_unused = ^agen_addr;

    for (genvar u = 0; u < N; u++) begin : g_slot
        assign ctl[u].issue  = issue_vld[u];
        assign ctl[u].retire = retire_vld[u];

        lsom_unit_slot #(.CW(CW)) i_slot (
            .clk         (clk),
            .rst         (rst),
            .issue       (issue_vld[u]),
            .retire      (retire_vld[u]),
            .agen_vld    (agen_vld[u]),
            .agen_low    (agen_addr[u*AW +: CW]),
            .outstanding (outstanding[u]),
            .known_eff   (known_eff[u]),
            .addr_eff    (addr_eff[u])
        );
    end

    // One comparator per unordered pair
    for (genvar a = 0; a < N; a++) begin : g_cmp_row
        for (genvar b = a + 1; b < N; b++) begin : g_cmp_col
            lsom_pair_cmp #(.CW(CW)) i_cmp (
                .known_a (known_eff[a]),
                .known_b (known_eff[b]),
                .addr_a  (addr_eff[a]),
                .addr_b  (addr_eff[b]),
                .differ  (pair_differ[tri_index(N, a, b)])
            );
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                assign dep_matrix[i*N+j] = 1'b0;
            end else begin : g_cell
                localparam int unsigned LO = (i < j) ? i : j;
                localparam int unsigned HI = (i < j) ? j : i;
                lsom_dep_cell i_cell (
                    .clk             (clk),
                    .rst             (rst),
                    .row_ctl         (ctl[i]),
                    .col_ctl         (ctl[j]),
                    .col_outstanding (outstanding[j]),
                    .differ          (pair_differ[tri_index(N, LO, HI)]),
                    .dep             (dep_matrix[i*N+j])
                );
            end
        end
        assign proceed[i] = ~|dep_matrix[i*N +: N];
    end

endmodule

// File: rtl/lsom_order_chk.sv
module lsom_order_chk #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    issue_vld,
    input logic [N-1:0]    agen_vld,
    input logic [N*AW-1:0] agen_addr,
    input logic [N-1:0]    retire_vld,
    input logic [N-1:0]    proceed,
    input logic [N*N-1:0]  dep_matrix
);
    for (genvar i = 0; i < N; i++) begin : g_i
        // R8
        retire_proceed_chk: assert property (@(posedge clk) disable iff (rst)
            retire_vld[i] |=> proceed[i]);

        for (genvar j = 0; j < N; j++) begin : g_j
            if (i != j) begin : g_off
                // R8
                retire_clear_chk: assert property (@(posedge clk) disable iff (rst)
                    retire_vld[i] |=> (!dep_matrix[i*N+j] && !dep_matrix[j*N+i]));

                // R2
                set_source_chk: assert property (@(posedge clk) disable iff (rst)
                    $rose(dep_matrix[i*N+j]) |-> $past(issue_vld[i]));

                // R4
                release_chk: assert property (@(posedge clk) disable iff (rst)
                    (agen_vld[i] && agen_vld[j] &&
                     !issue_vld[i] && !issue_vld[j] &&
                     !retire_vld[i] && !retire_vld[j] &&
                     (agen_addr[i*AW +: CW] != agen_addr[j*AW +: CW]))
                    |=> (!dep_matrix[i*N+j] && !dep_matrix[j*N+i]));

                // R5
                alias_keep_chk: assert property (@(posedge clk) disable iff (rst)
                    (dep_matrix[i*N+j] && agen_vld[i] && agen_vld[j] &&
                     !issue_vld[i] && !issue_vld[j] &&
                     !retire_vld[i] && !retire_vld[j] &&
                     (agen_addr[i*AW +: CW] == agen_addr[j*AW +: CW]))
                    |=> dep_matrix[i*N+j]);
            end
        end
    end
endmodule

bind lsu_order_matrix lsom_order_chk #(.N(N), .AW(AW), .CW(CW)) i_order_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_vld  (issue_vld),
    .agen_vld   (agen_vld),
    .agen_addr  (agen_addr),
    .retire_vld (retire_vld),
    .proceed    (proceed),
    .dep_matrix (dep_matrix)
);

// File: tb/test_lsu_order_matrix.sv
`timescale 1ns/1ps
module test_lsu_order_matrix;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int CW = 12;

    typedef struct {
        logic [N*N-1:0] dep;
        logic [N-1:0]   prc;
        string          tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    issue_vld  = '0;
    logic [N-1:0]    agen_vld   = '0;
    logic [N*AW-1:0] agen_addr  = '0;
    logic [N-1:0]    retire_vld = '0;
    logic [N-1:0]    proceed;
    logic [N*N-1:0]  dep_matrix;

    lsu_order_matrix #(.N(N), .AW(AW), .CW(CW)) i_lsu_order_matrix (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .agen_vld(agen_vld),
        .agen_addr(agen_addr), .retire_vld(retire_vld),
        .proceed(proceed), .dep_matrix(dep_matrix)
    );

    always #2 clk = ~clk;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;
    exp_t sb[$];

    // Reference state kept from the requirements
    logic [N*N-1:0] m_dep   = '0;
    logic [N-1:0]   m_out   = '0;
    logic [N-1:0]   m_known = '0;
    logic [CW-1:0]  m_addr [N];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] rows_empty(input logic [N*N-1:0] d);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = ~|d[i*N +: N];
        return r;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic [N-1:0] iss, input logic [N-1:0] agv,
                        input logic [N-1:0] ret,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [AW-1:0] a2, input logic [AW-1:0] a3,
                        input string tag);
        logic [AW-1:0]  av [N];
        logic [N-1:0]   ke;
        logic [CW-1:0]  ae [N];
        logic [N*N-1:0] nd;
        exp_t           e;
        @(negedge clk);
        av[0] = a0; av[1] = a1; av[2] = a2; av[3] = a3;
        issue_vld  = iss;
        agen_vld   = agv;
        retire_vld = ret;
        for (int k = 0; k < N; k++) agen_addr[k*AW +: AW] = av[k];
        for (int k = 0; k < N; k++) begin
            ke[k] = (m_known[k] | agv[k]) & ~iss[k] & ~ret[k];
            ae[k] = agv[k] ? av[k][CW-1:0] : m_addr[k];
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                if (i == j)                nd[i*N+j] = 1'b0;
                else if (ret[i] || ret[j]) nd[i*N+j] = 1'b0;
                else if (iss[i])           nd[i*N+j] = m_out[j];
                else if (iss[j])           nd[i*N+j] = 1'b0;
                else if (ke[i] && ke[j] && ae[i] != ae[j]) nd[i*N+j] = 1'b0;
                else                       nd[i*N+j] = m_dep[i*N+j];
            end
        m_dep = nd;
        for (int k = 0; k < N; k++) begin
            if (ret[k])      m_out[k] = 1'b0;
            else if (iss[k]) m_out[k] = 1'b1;
            if (ret[k] || iss[k]) m_known[k] = 1'b0;
            else if (agv[k]) begin
                m_known[k] = 1'b1;
                m_addr[k]  = av[k][CW-1:0];
            end
        end
        e.dep = nd;
        e.prc = rows_empty(nd);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step('0, '0, '0, '0, '0, '0, '0, tag);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(dep_matrix == e.dep, e.tag, "dep_matrix",
                      32'(dep_matrix), 32'(e.dep));
                check(proceed == e.prc, {e.tag, "/R10"}, "proceed",
                      32'(proceed), 32'(e.prc));
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) m_addr[k] = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(dep_matrix == '0, "R1", "dep_matrix in reset", 32'(dep_matrix), 0);
        check(proceed == '1, "R1", "proceed in reset", 32'(proceed), 32'hF);
        rst = 1'b0;
        @(posedge clk); #1;
        check(dep_matrix == '0, "R1", "dep_matrix after reset", 32'(dep_matrix), 0);

        // R2: first issue sees nothing outstanding
        step(4'b0001, '0, '0, '0, '0, '0, '0, "R2 issue u0");
        step(4'b0010, '0, '0, '0, '0, '0, '0, "R2 issue u1");
        // R2/R3: co-issued units do not wait on each other
        step(4'b1100, '0, '0, '0, '0, '0, '0, "R2/R3 co-issue u2 u3");
        // R5: equal low bits, different high bits keep (1,0)
        step('0, 4'b0011, '0, 32'h0000_1000, 32'h0000_2000, '0, '0, "R5 alias keep");
        idle("R7 stored hold");
        // R4/R6/R7: two arrivals compared with stored and with each other
        step('0, 4'b1100, '0, '0, '0, 32'h0000_0004, 32'h0000_1008, "R4/R6/R7 multi arrive");
        // R8: retire u0 clears its row and column
        step('0, '0, 4'b0001, '0, '0, '0, '0, "R8 retire u0");
        step(4'b0001, '0, '0, '0, '0, '0, '0, "R2 reissue u0");
        // R8: retire beats issue and address for the same unit
        step(4'b0010, 4'b0010, 4'b0010, '0, 32'h0000_0123, '0, '0, "R8/R9 retire wins");
        // R5/R4: u0 equal to u2, differs from u3
        step('0, 4'b0001, '0, 32'h0000_5004, '0, '0, '0, "R4/R5 u0 arrive");
        // R9: address in issue cycle ignored
        step(4'b0010, 4'b0010, '0, '0, 32'h0000_0999, '0, '0, "R9 agen on issue");
        idle("R9 no stored address");
        idle("R9 still waiting");
        step('0, 4'b0010, '0, '0, 32'h0000_3004, '0, '0, "R5/R7 u1 arrive");
        // R3: reissue u3 clears column 3 and reloads row 3
        step(4'b1000, '0, '0, '0, '0, '0, '0, "R3 reissue u3");
        step('0, '0, 4'b0111, '0, '0, '0, '0, "R8 multi retire");
        idle("R10 drained");
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule